// File: doc/BRIEF.md
# Serial Link Request Decoder

This block sits on the PHY side of the link interface. It samples the one-wire request line on every system clock edge and turns the serial frames the link sends into parallel events. It works out each frame's length from the frame's own type field, then decodes the frame as a bus request, a register read or a register write.

Bus requests become pending flags for the arbitration logic. Register writes update a small internal register file. Register reads produce a one-cycle strobe that carries the address and the register's current contents. The arbitration side supplies three inputs that clear pending flags: the PHY is driving the receive state, the bus was granted, or an isochronous transfer finished.

The line idles low. A frame starts with a 1 and ends with a 0 stop bit. All field bits are sent MSB first.

Top module: `lrq_decoder`

## Requirements
- R1: A frame begins on the first sampled 1 while idle. It is followed by a 3-bit type field, sent MSB first, then a body, then a stop bit. The body length depends on the type: 2 speed bits for types 000, 001, 010, 011, 110 and 111 (7-bit frame); a 4-bit address for type 100 (9-bit frame); a 4-bit address then 8 data bits for type 101 (17-bit frame). A new frame may start on the cycle right after a stop bit.
- R2: If the bit in the stop position is 1, the whole frame is dropped and none of the outputs change. The decoder then ignores the line until it has sampled a 0, and only after that looks for a start bit again.
- R3: A complete frame of type 000 (take-bus), 001 (isochronous), 010 (priority) or 011 (fair) sets pend_o bit 0, 1, 2 or 3 respectively. The bit becomes visible one cycle after the clock edge that sampled the stop bit.
- R4: Types 110 and 111 are consumed as 7-bit frames. They update req_type_o but set no pending bit.
- R5: The register file has 8 entries of 8 bits, all reset to 0. A complete write frame loads its data into the entry at its address, one cycle after the stop edge. A write to address 8 to 15 changes nothing.
- R6: A complete read frame (type 100) raises rd_stb_o for exactly one cycle, right after the stop edge. At the same time rd_addr_o carries the frame's address and rd_data_o carries that entry's contents, or 0 for address 8 to 15.
- R7: While rx_busy_i is 1, the priority and fair pending bits are cleared, and a priority or fair frame that completes in that cycle is not posted. The take-bus and isochronous bits are unaffected by rx_busy_i.
- R8: The isochronous pending bit is cleared when iso_done_i is 1. It is also cleared when any complete frame of a type other than 001 arrives. An isochronous frame that completes in the same cycle as iso_done_i still sets the bit.
- R9: grant_i clears the take-bus, priority and fair pending bits and leaves the isochronous bit alone. A frame that completes in the same cycle as grant_i still sets its bit.
- R10: req_type_o holds the type of the last complete frame.
- R11: After reset, pend_o = 0000, req_type_o = 000 and rd_stb_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_line_i | input | 1 | Serial request line from the link |
| rx_busy_i | input | 1 | PHY is driving the receive state |
| grant_i | input | 1 | Bus granted to the pending non-isochronous request |
| iso_done_i | input | 1 | Isochronous transfer finished |
| pend_o | output | 4 | Pending flags: take-bus, isochronous, priority, fair (bit 0 to 3) |
| req_type_o | output | 3 | Type of the last complete frame |
| rd_stb_o | output | 1 | One-cycle register read strobe |
| rd_addr_o | output | 4 | Address of the read request |
| rd_data_o | output | 8 | Contents of the addressed register |

## Verification
The hardest case to reach is the resynchronisation after a bad stop bit. A decoder that looks for a new start bit too early only fails if the bits that follow happen to form a valid frame.

The stimulus drives a 1 in the stop position and then holds the line high for exactly five more cycles before it returns low. A decoder that restarts too early would read those bits as a well-formed reserved frame and change req_type_o.

Random frames with random flag-clearing inputs, applied on every cycle, cover the cases where a frame completes in the same cycle as a clear.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
  localparam int unsigned TYPE_W = 3;
  localparam int unsigned NFLAG  = 4;

  typedef enum logic [TYPE_W-1:0] {
    RQ_TAKE = 3'd0,
    RQ_ISO  = 3'd1,
    RQ_PRI  = 3'd2,
    RQ_FAIR = 3'd3,
    RQ_RD   = 3'd4,
    RQ_WR   = 3'd5,
    RQ_RSV6 = 3'd6,
    RQ_RSV7 = 3'd7
  } rq_type_e;
endpackage

// File: rtl/lrq_deser.sv
module lrq_deser
  import lrq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SPD_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              frm_vld_o,
  output rq_type_e          frm_type_o,
  output logic [ADDR_W-1:0] frm_addr_o,
  output logic [DATA_W-1:0] frm_data_o
);
  localparam int unsigned SH_W  = ADDR_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(TYPE_W + SH_W + 1);
  localparam logic [CNT_W-1:0] TYPE_END = CNT_W'(TYPE_W - 1);
  localparam logic [CNT_W-1:0] STOP_BUS = CNT_W'(TYPE_W + SPD_W);
  localparam logic [CNT_W-1:0] STOP_RD  = CNT_W'(TYPE_W + ADDR_W);
  localparam logic [CNT_W-1:0] STOP_WR  = CNT_W'(TYPE_W + SH_W);

  typedef enum logic [1:0] {S_HUNT, S_BITS, S_DRAIN} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  sh_q;
  rq_type_e         type_q;
  logic [CNT_W-1:0] stop_idx;
  logic             at_stop;

  always_comb begin
    unique case (type_q)
      RQ_RD:   stop_idx = STOP_RD;
      RQ_WR:   stop_idx = STOP_WR;
      default: stop_idx = STOP_BUS;
    endcase
  end

  // type_q is stale until the type field is in; stop_idx always lies beyond it
  assign at_stop = (st_q == S_BITS) && (cnt_q > TYPE_END) && (cnt_q == stop_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_HUNT;
      cnt_q      <= '0;
      sh_q       <= '0;
      type_q     <= RQ_TAKE;
      frm_vld_o  <= 1'b0;
      frm_type_o <= RQ_TAKE;
      frm_addr_o <= '0;
      frm_data_o <= '0;
    end else begin
      frm_vld_o <= 1'b0;
      unique case (st_q)
        S_HUNT: begin
          if (line_i) begin
            st_q  <= S_BITS;
            cnt_q <= '0;
          end
        end
        S_BITS: begin
          sh_q <= {sh_q[SH_W-2:0], line_i};
          if (cnt_q == TYPE_END) type_q <= rq_type_e'({sh_q[TYPE_W-2:0], line_i});
          if (at_stop) begin
            if (!line_i) begin
              st_q       <= S_HUNT;
              frm_vld_o  <= 1'b1;
              frm_type_o <= type_q;
              frm_addr_o <= '0;
              frm_data_o <= '0;
              if (type_q == RQ_RD) frm_addr_o <= sh_q[ADDR_W-1:0];
              if (type_q == RQ_WR) begin
                frm_addr_o <= sh_q[SH_W-1:DATA_W];
                frm_data_o <= sh_q[DATA_W-1:0];
              end
            end else begin
              st_q <= S_DRAIN;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DRAIN: if (!line_i) st_q <= S_HUNT;
        default: st_q <= S_HUNT;
      endcase
    end
  end

  // R2
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_o |-> !$past(line_i));
  // R1
  frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_o |=> !frm_vld_o);
endmodule

// File: rtl/lrq_regfile.sv
module lrq_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int e = 0; e < int'(NREG); e++) begin
        if (we_i && int'(waddr_i) == e) mem_q[e] <= wdata_i;
      end
    end
  end

  assign rdata_o = (int'(raddr_i) < int'(NREG)) ? mem_q[raddr_i[IDX_W-1:0]] : '0;

  // R5
  oob_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(waddr_i) >= int'(NREG)) |=> $stable(mem_q));
endmodule

// File: rtl/lrq_pend.sv
module lrq_pend
  import lrq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_vld_i,
  input  rq_type_e         ev_type_i,
  input  logic             rx_busy_i,
  input  logic             grant_i,
  input  logic             iso_done_i,
  output logic [NFLAG-1:0] pend_o,
  output rq_type_e         last_type_o
);
  logic ev_bus;
  assign ev_bus = ev_vld_i && !ev_type_i[TYPE_W-1];

  for (genvar k = 0; k < int'(NFLAG); k++) begin : g_flag
    localparam bit IS_ISO = (k == int'(RQ_ISO));
    localparam bit IS_ARB = (k == int'(RQ_PRI)) || (k == int'(RQ_FAIR));
    logic q, set, clr;

    assign set = ev_bus && (int'(ev_type_i) == k) && !(IS_ARB && rx_busy_i);
    if (IS_ISO) begin : g_iso
      assign clr = iso_done_i || (ev_vld_i && ev_type_i != RQ_ISO);
    end else begin : g_oth
      assign clr = grant_i || (IS_ARB && rx_busy_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
    end
    assign pend_o[k] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_type_o <= RQ_TAKE;
    else if (ev_vld_i) last_type_o <= ev_type_i;
  end

  // R7
  rx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_busy_i |=> !pend_o[RQ_PRI] && !pend_o[RQ_FAIR]);
  // R9
  grant_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !(ev_vld_i && ev_type_i == RQ_TAKE)) |=> !pend_o[RQ_TAKE]);
  // R8
  iso_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_done_i && !(ev_vld_i && ev_type_i == RQ_ISO)) |=> !pend_o[RQ_ISO]);
  // R3
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend_o) > $countones($past(pend_o)) |-> $past(ev_bus));
endmodule

// File: rtl/lrq_decoder.sv
module lrq_decoder
  import lrq_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SPD_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_line_i,
  input  logic              rx_busy_i,
  input  logic              grant_i,
  input  logic              iso_done_i,
  output logic [3:0]        pend_o,
  output logic [2:0]        req_type_o,
  output logic              rd_stb_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              frm_vld;
  rq_type_e          frm_type;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;
  rq_type_e          last_type;

  lrq_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPD_W(SPD_W)) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (req_line_i),
    .frm_vld_o  (frm_vld),
    .frm_type_o (frm_type),
    .frm_addr_o (frm_addr),
    .frm_data_o (frm_data)
  );

  lrq_regfile #(.NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (frm_vld && frm_type == RQ_WR),
    .waddr_i (frm_addr),
    .wdata_i (frm_data),
    .raddr_i (frm_addr),
    .rdata_o (rd_data_o)
  );

  lrq_pend u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_vld_i    (frm_vld),
    .ev_type_i   (frm_type),
    .rx_busy_i   (rx_busy_i),
    .grant_i     (grant_i),
    .iso_done_i  (iso_done_i),
    .pend_o      (pend_o),
    .last_type_o (last_type)
  );

  assign rd_stb_o   = frm_vld && frm_type == RQ_RD;
  assign rd_addr_o  = frm_addr;
  assign req_type_o = last_type;

  // R6
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |=> !rd_stb_o);
endmodule

// File: tb/sim_lrq_decoder.sv
module sim_lrq_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_line_i = 1'b0;
  logic       rx_busy_i = 1'b0;
  logic       grant_i = 1'b0;
  logic       iso_done_i = 1'b0;
  logic [3:0] pend_o;
  logic [2:0] req_type_o;
  logic       rd_stb_o;
  logic [3:0] rd_addr_o;
  logic [7:0] rd_data_o;

  lrq_decoder u0 (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [8];
  logic [3:0] m_pend = '0;
  logic [2:0] m_type = '0;
  logic       ev_v = 1'b0;
  logic [2:0] ev_t = '0;
  logic [3:0] ev_a = '0;
  logic [7:0] ev_d = '0;
  logic       rd_exp = 1'b0;
  logic [3:0] rd_exp_a = '0;
  logic       sd_rx = 1'b0, sd_gr = 1'b0, sd_id = 1'b0;
  bit         rnd_side = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] reg_val(input logic [3:0] a);
    return (a < 4'd8) ? m_reg[a[2:0]] : 8'h00;
  endfunction

  // one clock: check at negedge, drive, then advance the model at posedge
  task automatic step(input logic b, input logic good, input logic [2:0] t,
                      input logic [3:0] a, input logic [7:0] d);
    logic [3:0] nxt;
    @(negedge clk_i);
    chk(pend_o == m_pend, "R3 pend", 32'(pend_o), 32'(m_pend));
    chk(req_type_o == m_type, "R10 type", 32'(req_type_o), 32'(m_type));
    chk(rd_stb_o == rd_exp, "R6 strobe", 32'(rd_stb_o), 32'(rd_exp));
    if (rd_exp) begin
      chk(rd_addr_o == rd_exp_a, "R6 addr", 32'(rd_addr_o), 32'(rd_exp_a));
      chk(rd_data_o == reg_val(rd_exp_a), "R6 data", 32'(rd_data_o), 32'(reg_val(rd_exp_a)));
    end
    if (rnd_side) begin
      sd_rx = ($urandom % 8) == 0;
      sd_gr = ($urandom % 6) == 0;
      sd_id = ($urandom % 6) == 0;
    end
    req_line_i = b; rx_busy_i = sd_rx; grant_i = sd_gr; iso_done_i = sd_id;
    @(posedge clk_i);
    nxt = m_pend;
    if (sd_gr) begin nxt[0] = 1'b0; nxt[2] = 1'b0; nxt[3] = 1'b0; end
    if (sd_rx) begin nxt[2] = 1'b0; nxt[3] = 1'b0; end
    if (sd_id) nxt[1] = 1'b0;
    if (ev_v) begin
      m_type = ev_t;
      if (ev_t != 3'd1) nxt[1] = 1'b0;
      if (ev_t < 3'd4 && !(sd_rx && (ev_t == 3'd2 || ev_t == 3'd3))) nxt[ev_t[1:0]] = 1'b1;
      if (ev_t == 3'd5 && ev_a < 4'd8) m_reg[ev_a[2:0]] = ev_d;
    end
    m_pend = nxt;
    rd_exp = good && t == 3'd4;
    rd_exp_a = a;
    ev_v = good; ev_t = t; ev_a = a; ev_d = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 4'd0, 8'd0);
  endtask

  task automatic send(input logic [2:0] t, input logic [3:0] a, input logic [7:0] d, input logic bad);
    logic [16:0] v;
    int n;
    if (t == 3'd4) begin v = {8'd0, 1'b1, t, a, bad}; n = 9; end
    else if (t == 3'd5) begin v = {1'b1, t, a, d, bad}; n = 17; end
    else begin v = {10'd0, 1'b1, t, d[1:0], bad}; n = 7; end
    for (int i = 0; i < n; i++)
      step(v[n-1-i], (i == n-1) && !bad, t, (t >= 3'd4 && t <= 3'd5) ? a : 4'd0, (t == 3'd5) ? d : 8'd0);
  endtask

  task automatic probe;
    #1;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    void'($urandom(32'd1394));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    probe();
    // R11
    chk(pend_o == 4'd0, "R11 pend", 32'(pend_o), 0);
    chk(rd_stb_o == 1'b0, "R11 strobe", 32'(rd_stb_o), 0);
    chk(req_type_o == 3'd0, "R11 type", 32'(req_type_o), 0);
    idle(2);

    // R3: each bus type sets its own flag
    for (int t = 0; t < 4; t++) begin
      send(3'(t), 4'd0, 8'd0, 1'b0); idle(1); probe();
      chk(pend_o[t] == 1'b1, "R3 set", 32'(pend_o), 32'(1 << t));
    end
    // iso was cleared by the later priority and fair frames (R8)
    chk(pend_o == 4'b1101, "R8 other-type clear", 32'(pend_o), 32'hd);

    // R9: grant clears take/pri/fair only
    send(3'd1, 4'd0, 8'd0, 1'b0); idle(1);
    sd_gr = 1'b1; idle(1); sd_gr = 1'b0; idle(1); probe();
    chk(pend_o == 4'b0010, "R9 grant", 32'(pend_o), 32'h2);

    // R8: iso_done clears iso
    sd_id = 1'b1; idle(1); sd_id = 1'b0; idle(1); probe();
    chk(pend_o == 4'b0000, "R8 iso_done", 32'(pend_o), 0);

    // R7: receive state suppresses fair/pri, not take/iso
    sd_rx = 1'b1;
    send(3'd3, 4'd0, 8'd0, 1'b0); send(3'd2, 4'd0, 8'd0, 1'b0);
    send(3'd0, 4'd0, 8'd0, 1'b0); send(3'd1, 4'd0, 8'd0, 1'b0); idle(1); probe();
    chk(pend_o == 4'b0011, "R7 suppress", 32'(pend_o), 32'h3);
    sd_rx = 1'b0;
    send(3'd3, 4'd0, 8'd0, 1'b0); idle(1);
    sd_rx = 1'b1; idle(1); sd_rx = 1'b0; idle(1); probe();
    chk(pend_o[3] == 1'b0, "R7 clear", 32'(pend_o), 0);

    // R4: reserved frames, no new flag (clears iso per R8)
    sd_gr = 1'b1; idle(1); sd_gr = 1'b0;
    send(3'd6, 4'd0, 8'd0, 1'b0); idle(1); probe();
    chk(req_type_o == 3'd6 && pend_o == 4'd0, "R4 rsv6", {req_type_o, pend_o}, 32'h60);
    send(3'd7, 4'd0, 8'd0, 1'b0); idle(1); probe();
    chk(req_type_o == 3'd7 && pend_o == 4'd0, "R4 rsv7", {req_type_o, pend_o}, 32'h70);

    // R5/R6: write, read back, out-of-range write
    send(3'd5, 4'd4, 8'hA5, 1'b0);
    send(3'd5, 4'd12, 8'h3C, 1'b0);
    send(3'd4, 4'd4, 8'd0, 1'b0); probe();
    chk(rd_stb_o && rd_data_o == 8'hA5, "R6 read back", 32'(rd_data_o), 32'hA5);
    send(3'd4, 4'd12, 8'd0, 1'b0); probe();
    chk(rd_stb_o && rd_data_o == 8'h00, "R5 oob write", 32'(rd_data_o), 0);
    idle(1);

    // R2: bad stop, line held high exactly long enough to fake a frame
    send(3'd2, 4'd0, 8'd0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 3'd0, 4'd0, 8'd0);
    idle(3); probe();
    chk(req_type_o == 3'd4 && pend_o == 4'd0, "R2 discard", {req_type_o, pend_o}, 32'h40);

    // R1: back-to-back frames with no gap
    send(3'd5, 4'd7, 8'h81, 1'b0); send(3'd4, 4'd7, 8'd0, 1'b0); probe();
    chk(rd_stb_o && rd_data_o == 8'h81, "R1 back-to-back", 32'(rd_data_o), 32'h81);
    idle(1);

    // random mix
    rnd_side = 1'b1;
    for (int f = 0; f < 500; f++) begin
      logic [2:0] t;
      logic bad;
      t = 3'($urandom);
      bad = ($urandom % 10) == 0;
      send(t, 4'($urandom), 8'($urandom), bad);
      if (bad) for (int i = 0; i < int'($urandom % 4); i++) step(1'b1, 1'b0, 3'd0, 4'd0, 8'd0);
      idle(bad ? 1 + int'($urandom % 3) : int'($urandom % 3));
    end
    rnd_side = 1'b0; sd_rx = 1'b0; sd_gr = 1'b0; sd_id = 1'b0;
    idle(3);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule